// File: doc/BRIEF.md
# ALU with Condition-Flag Status Register

This block is the integer execute stage of a small processor core. It takes two 32-bit operands and an operation code. It computes an add, a subtract, a compare or a bitwise AND, OR or XOR, and signals whether the result should be written back. Next to the arithmetic sits a 32-bit status register. Its top four bits hold the Negative, Zero, Carry and Overflow flags. When a flag-setting operation executes, these flags are updated at the next clock edge.

A compare is a subtract whose difference is shown on the result bus but never written back. It always refreshes the flags. Other operations refresh them only when the set-flags input is high. The lower 28 bits of the status word hold interrupt-mask, state-select and mode fields. The unit only stores these bits: it loads them through a control write port and they have no other effect. A small condition evaluator reads the stored Zero flag and reports whether an equal or a not-equal condition holds. A following conditional branch can act on the flags left by an earlier compare.

Top module: `alu_status_unit`

## Requirements
- R1: With `op_code` 0 (add), `result` equals `op_a + op_b` modulo 2^32 and `result_we` is 1, in the same cycle.
- R2: With `op_code` 1 (subtract), `result` equals `op_a - op_b` modulo 2^32 and `result_we` is 1.
- R3: With `op_code` 3, 4 or 5, `result` is the bitwise AND, OR or XOR of the operands, and `result_we` is 1.
- R4: With `op_code` 2 (compare), `result` shows `op_a - op_b` and `result_we` is 0. The flags update at the next edge whether or not `set_flags` is high.
- R5: After a flag update, N (`status[31]`) equals bit 31 of the result, and Z (`status[30]`) is 1 exactly when all 32 result bits are zero.
- R6: After a flag-setting add, C (`status[29]`) is the carry out of bit 31.
- R7: After a flag-setting subtract or compare, C is 1 when no borrow occurred, i.e. `op_a >= op_b` unsigned, and 0 otherwise.
- R8: After a flag-setting add, subtract or compare, V (`status[28]`) is 1 exactly when the signed two's-complement result overflowed.
- R9: A flag-setting AND, OR or XOR updates N and Z but leaves C and V at their previous values.
- R10: The flags change only at a rising clock edge, and only after a compare or an operation with `set_flags` high. Opcodes 6 and 7 give `result` 0 and `result_we` 0, and never change the flags.
- R11: `status[27:0]` is loaded from `ctl_wdata` at an edge where `ctl_wr` is 1, and holds otherwise. A control write and a flag update in the same cycle both take effect.
- R12: `cond_true` is combinational from the stored Z flag. With `cond_sel` 0 (equal) it is Z. With `cond_sel` 1 (not equal) it is the inverse of Z.
- R13: An asynchronous active-low reset clears the whole status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 3 | 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 and 7 no operation |
| set_flags | input | 1 | Update the flags at the next edge for add, subtract and logic operations |
| ctl_wr | input | 1 | Load the control field of the status word |
| ctl_wdata | input | 28 | New value for status bits 27:0 |
| cond_sel | input | 1 | Condition to evaluate: 0 equal, 1 not equal |
| result | output | 32 | Operation result, combinational |
| result_we | output | 1 | Result should be written back |
| status | output | 32 | Status word: N, Z, C, V in bits 31..28, control field below |
| cond_true | output | 1 | Selected condition holds on the stored flags |

## Verification
Two writes can reach the status register in the same cycle: a flag update from the arithmetic path and a control-field write. The bench drives a flag-setting subtract together with `ctl_wr`. It then checks that the top nibble carries the new flags and the lower 28 bits carry the written data. Two further cases are driven on their own: a control write while flags hold, and a flag update with no control write. Each is judged at the ports after the edge, so a mux that lets one source mask the other is exposed. The checker adds a cycle-by-cycle rule: each field follows its own source.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN  = 32;
  localparam int NFLAG = 4;
  localparam int CTLW  = XLEN - NFLAG;
  localparam int OPW   = 3;
  localparam int MSB   = XLEN - 1;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_ORR = 3'd4,
    OP_EOR = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // adder with carry in, carry out at bit XLEN
  function automatic logic [XLEN:0] wide_add(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y,
                                             input logic            cin);
    return {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
  endfunction

  // signed overflow: same-sign inputs giving a sign-flipped sum
  function automatic logic sgn_ovf(input logic [XLEN-1:0] x,
                                   input logic [XLEN-1:0] y,
                                   input logic [XLEN-1:0] r);
    return (x[MSB] == y[MSB]) && (r[MSB] != x[MSB]);
  endfunction

  function automatic logic is_zero(input logic [XLEN-1:0] r);
    return (r == '0);
  endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [OPW-1:0]  op,
  input  nzcv_t           flags_q,
  output logic [XLEN-1:0] res,
  output logic            res_we,
  output nzcv_t           flags_d,
  output logic            arith_op,
  output logic            logic_op,
  output logic            cmp_op
);
  logic            sub_mode;
  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   sum;

  assign sub_mode = (op == OP_SUB) || (op == OP_CMP);
  assign b_eff    = sub_mode ? ~b : b;
  assign sum      = wide_add(a, b_eff, sub_mode);

  always_comb begin
    res      = '0;
    res_we   = 1'b0;
    arith_op = 1'b0;
    logic_op = 1'b0;
    cmp_op   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res      = sum[XLEN-1:0];
        res_we   = 1'b1;
        arith_op = 1'b1;
      end
      OP_CMP: begin
        res      = sum[XLEN-1:0];
        arith_op = 1'b1;
        cmp_op   = 1'b1;
      end
      OP_AND: begin res = a & b; res_we = 1'b1; logic_op = 1'b1; end
      OP_ORR: begin res = a | b; res_we = 1'b1; logic_op = 1'b1; end
      OP_EOR: begin res = a ^ b; res_we = 1'b1; logic_op = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    flags_d.n = res[MSB];
    flags_d.z = is_zero(res);
    flags_d.c = arith_op ? sum[XLEN] : flags_q.c;
    flags_d.v = arith_op ? sgn_ovf(a, b_eff, sum[XLEN-1:0]) : flags_q.v;
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_we,
  input  nzcv_t           flag_nxt,
  input  logic            ctl_we,
  input  logic [CTLW-1:0] ctl_nxt,
  output nzcv_t           flag_q,
  output logic [CTLW-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval (
  input  logic z_flag,
  input  logic sel_ne,
  output logic holds
);
  assign holds = sel_ne ? ~z_flag : z_flag;
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XLEN-1:0]      op_a,
  input  logic [XLEN-1:0]      op_b,
  input  logic [OPW-1:0]       op_code,
  input  logic                 set_flags,
  input  logic                 ctl_wr,
  input  logic [CTLW-1:0]      ctl_wdata,
  input  logic                 cond_sel,
  output logic [XLEN-1:0]      result,
  output logic                 result_we,
  output logic [XLEN-1:0]      status,
  output logic                 cond_true
);
  nzcv_t           flags_q;
  nzcv_t           flags_d;
  logic [CTLW-1:0] ctl_q;
  logic            arith_evt;
  logic            logic_evt;
  logic            cmp_evt;
  logic            flag_upd_evt;

  alu_core u_core (
    .a        (op_a),
    .b        (op_b),
    .op       (op_code),
    .flags_q  (flags_q),
    .res      (result),
    .res_we   (result_we),
    .flags_d  (flags_d),
    .arith_op (arith_evt),
    .logic_op (logic_evt),
    .cmp_op   (cmp_evt)
  );

  // compare always refreshes flags; others need set_flags
  assign flag_upd_evt = cmp_evt || (set_flags && (arith_evt || logic_evt));

  status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_we  (flag_upd_evt),
    .flag_nxt (flags_d),
    .ctl_we   (ctl_wr),
    .ctl_nxt  (ctl_wdata),
    .flag_q   (flags_q),
    .ctl_q    (ctl_q)
  );

  assign status = {flags_q, ctl_q};

  cond_eval u_cond (
    .z_flag (flags_q.z),
    .sel_ne (cond_sel),
    .holds  (cond_true)
  );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
  import alu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [OPW-1:0]  op_code,
  input logic            ctl_wr,
  input logic [CTLW-1:0] ctl_wdata,
  input logic            cond_sel,
  input logic [XLEN-1:0] result,
  input logic            result_we,
  input logic [XLEN-1:0] status,
  input logic            cond_true,
  input logic            flag_upd_evt,
  input logic            logic_evt
);
  logic            fresh, prev_ok, prev_upd, prev_logic, prev_ctl_wr;
  logic [XLEN-1:0] prev_res, prev_stat;
  logic [CTLW-1:0] prev_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b1; prev_ok <= 1'b0; prev_upd <= 1'b0; prev_logic <= 1'b0;
      prev_ctl_wr <= 1'b0; prev_res <= '0; prev_stat <= '0; prev_ctl <= '0;
    end else begin
      fresh <= 1'b0; prev_ok <= 1'b1; prev_upd <= flag_upd_evt;
      prev_logic <= logic_evt; prev_ctl_wr <= ctl_wr; prev_res <= result;
      prev_stat <= status; prev_ctl <= ctl_wdata;
    end
  end

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP) |-> !result_we);
  // R5
  nz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_upd) |-> (status[XLEN-1] == prev_res[XLEN-1]) &&
                              (status[XLEN-2] == (prev_res == '0)));
  // R9
  logic_cv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && prev_upd && prev_logic) |->
      (status[XLEN-3:XLEN-4] == prev_stat[XLEN-3:XLEN-4]));
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && !prev_upd) |-> (status[XLEN-1:CTLW] == prev_stat[XLEN-1:CTLW]));
  // R11
  ctl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> (status[CTLW-1:0] == (prev_ctl_wr ? prev_ctl : prev_stat[CTLW-1:0])));
  // R12
  cond_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_true == (status[XLEN-2] ^ cond_sel));
  // R13
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (status == '0));
endmodule

bind alu_status_unit alu_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_code      (op_code),
  .ctl_wr       (ctl_wr),
  .ctl_wdata    (ctl_wdata),
  .cond_sel     (cond_sel),
  .result       (result),
  .result_we    (result_we),
  .status       (status),
  .cond_true    (cond_true),
  .flag_upd_evt (flag_upd_evt),
  .logic_evt    (logic_evt)
);

// File: tb/tb_alu_status_unit.sv
`timescale 1ns/1ps
module tb_alu_status_unit;
  localparam real CLK_NS = 8.0;
  localparam int  NV     = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [2:0]  op_code;
  logic        set_flags, ctl_wr, cond_sel;
  logic [27:0] ctl_wdata;
  logic [31:0] result, status;
  logic        result_we, cond_true;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  alu_status_unit dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .set_flags(set_flags), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cond_sel(cond_sel), .result(result), .result_we(result_we),
    .status(status), .cond_true(cond_true)
  );

  // {op[104:102], a[101:70], b[69:38], sf[37], res[36:5], we[4], nzcv[3:0]}
  localparam logic [104:0] VEC [NV] = '{
    {3'd0, 32'h00000001, 32'h00000002, 1'b1, 32'h00000003, 1'b1, 4'b0000}, // R1
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 1'b1, 32'h00000000, 1'b1, 4'b0110}, // R6
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 32'h80000000, 1'b1, 4'b1001}, // R8
    {3'd0, 32'h80000000, 32'h80000000, 1'b1, 32'h00000000, 1'b1, 4'b0111}, // R8
    {3'd1, 32'h00000005, 32'h00000003, 1'b1, 32'h00000002, 1'b1, 4'b0010}, // R2 R7
    {3'd1, 32'h00000003, 32'h00000005, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R7
    {3'd1, 32'h80000000, 32'h00000001, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R8
    {3'd3, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 32'h00000000, 1'b1, 4'b0111}, // R3 R9
    {3'd4, 32'h80000000, 32'h00000001, 1'b1, 32'h80000001, 1'b1, 4'b1011}, // R9
    {3'd5, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, 32'h00000000, 1'b1, 4'b1011}, // R10
    {3'd0, 32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 1'b1, 4'b1011}, // R10
    {3'd2, 32'h00000007, 32'h00000007, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R4
    {3'd2, 32'h00000000, 32'h00000001, 1'b1, 32'hFFFFFFFF, 1'b0, 4'b1000}, // R4 R7
    {3'd6, 32'h00000005, 32'h00000005, 1'b1, 32'h00000000, 1'b0, 4'b1000}, // R10
    {3'd1, 32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 4'b0110}, // R5
    {3'd5, 32'hFFFF0000, 32'h0000FFFF, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1010}  // R5 R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic cw, input logic [27:0] cd);
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; set_flags = sf; ctl_wr = cw; ctl_wdata = cd;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
    ctl_wr = 1'b0; set_flags = 1'b0; op_code = 3'd6;
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; op_code = 3'd6; set_flags = 1'b0;
    ctl_wr = 1'b0; ctl_wdata = '0; cond_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 reset status", status, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R12 EQ after reset", {31'b0, cond_true}, 32'd0);
    cond_sel = 1'b1; #1;
    chk("R12 NE after reset", {31'b0, cond_true}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][104:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37], 1'b0, 28'h0);
      chk($sformatf("R1-3 result vec%0d", i), result, VEC[i][36:5]);
      chk($sformatf("R4 write enable vec%0d", i), {31'b0, result_we}, {31'b0, VEC[i][4]});
      after_edge();
      chk($sformatf("R5 R6 R7 R8 R9 R10 flags vec%0d", i), {28'b0, status[31:28]},
          {28'b0, VEC[i][3:0]});
      chk($sformatf("R11 ctl field vec%0d", i), {4'b0, status[27:0]}, 32'h0);
      cond_sel = 1'b0; #1;
      chk($sformatf("R12 EQ vec%0d", i), {31'b0, cond_true}, {31'b0, VEC[i][2]});
      cond_sel = 1'b1; #1;
      chk($sformatf("R12 NE vec%0d", i), {31'b0, cond_true}, {31'b0, ~VEC[i][2]});
    end

    // R11: control write alone, flags hold (R10)
    drive(3'd0, 32'h1, 32'h1, 1'b0, 1'b1, 28'h00000D3);
    after_edge();
    chk("R11 ctl write alone", status, {4'b1010, 28'h00000D3});

    // R11: control write and flag update in the same cycle
    drive(3'd1, 32'h1, 32'h1, 1'b1, 1'b1, 28'h0000010);
    after_edge();
    chk("R11 simultaneous write", status, {4'b0110, 28'h0000010});

    // R8: flag update with no control write keeps control field
    drive(3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b0, 28'hFFFFFFF);
    chk("R1 add overflow result", result, 32'hFFFFFFFE);
    after_edge();
    chk("R8 R11 flags only", status, {4'b1001, 28'h0000010});

    // R13: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R13 async clear", status, 32'h0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R13 stays clear", status, 32'h0);

    finish_run();
  end
endmodule